// File: doc/BRIEF.md
# Prioritized Fetch Address Selector

This block picks the address of the next instruction-fetch group from every candidate the pipeline offers in a cycle. The candidates are, from lowest to highest priority: the sequential successor of the current group, a predicted target from the branch target cache, a correction from decode, a correction from dispatch, and a correction from branch execution. The later a stage sits in the pipeline, the more it knows, so its candidate wins. The chosen address is registered as the current fetch address on the next clock edge.

From the current fetch address the block also works out how many instructions the group holds. A group is at most four instructions and never crosses a 32-byte cache block of eight instructions, so it shrinks to what is left of the block. For every redirect the block raises a kill for each younger stage holding wrong-path work, and it reports the number of fetch cycles the redirect has cost. A decode correction whose target comes from the link or count register is refused while an update to that register is still pending.

Top module: `fetch_addr_sel`

## Requirements
- R1: While rst_n is low and in the first cycle after it, fetch_addr_o equals the reset vector 0x0000_1000, and kill_o is 0.
- R2: group_o equals the smaller of four and the number of instructions left in the 32-byte block, that is 8 minus address bits [4:2].
- R3: With no redirect, no target-cache hit and no stall, fetch_addr_o on the next cycle equals the current fetch_addr_o plus 4 times group_o.
- R4: A target-cache hit (btac_hit_i) with no redirect and no stall makes btac_tgt_i the next fetch address, with kill_o 0 and penalty_o 0.
- R5: stall_i with no accepted redirect holds fetch_addr_o, even when btac_hit_i is high.
- R6: Priority from highest to lowest is execute, dispatch, decode, target-cache hit, sequential.
- R7: kill_o bit 0 names the fetch stage, bit 1 decode, bit 2 dispatch; an execute redirect drives 3'b111, dispatch 3'b011, decode 3'b001, otherwise 3'b000.
- R8: penalty_o is 3 for an execute redirect, 2 for dispatch, 1 for decode and 0 otherwise.
- R9: A decode redirect with dec_via_lnk_i high is ignored while lnk_pend_i is high; selection then falls to the lower candidates.
- R10: An accepted redirect from any stage is taken even when stall_i is high.
- R11: The next fetch address always has bits [1:0] cleared, whatever the low bits of the chosen target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Fetch cannot advance this cycle |
| btac_hit_i | input | 1 | Target cache hit for the current fetch address |
| btac_tgt_i | input | 32 | Predicted target from the target cache |
| dec_redir_i | input | 1 | Decode offers a corrected address |
| dec_tgt_i | input | 32 | Decode correction address |
| dec_via_lnk_i | input | 1 | Decode correction takes its target from the link or count register |
| lnk_pend_i | input | 1 | An update to the link or count register is in flight |
| dsp_redir_i | input | 1 | Dispatch offers a corrected address |
| dsp_tgt_i | input | 32 | Dispatch correction address |
| exe_redir_i | input | 1 | Branch execution offers a corrected address |
| exe_tgt_i | input | 32 | Branch execution correction address |
| fetch_addr_o | output | 32 | Current fetch address |
| group_o | output | 3 | Instructions in the current fetch group (1 to 4) |
| next_addr_o | output | 32 | Selected next fetch address |
| kill_o | output | 3 | Flush for fetch, decode and dispatch stages |
| penalty_o | output | 2 | Fetch cycles lost to the selected redirect |

## Verification
Sequential selection is tried from each word offset near the end of a block, which separates a full four-instruction group from groups of three, two and one and shows whether the step crosses the block edge correctly. The candidates are then offered in overlapping combinations, so each pair in the priority order is seen with both members present and a wrong ordering picks a visibly different target. Stall is combined with a hit and with each redirect to tell holding from overriding, and the decode correction is offered with and without a pending link update to show the qualification. An unaligned target confirms the low address bits are cleared.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

   typedef enum logic [2:0] {
      SEL_SEQ  = 3'd0,
      SEL_HOLD = 3'd1,
      SEL_BTAC = 3'd2,
      SEL_REDIR = 3'd3
   } fsel_src_e;

   localparam int unsigned INSTR_BYTES = 4;
   localparam int unsigned INSTR_SHIFT = 2;

endpackage

// File: rtl/fsel_group.sv
module fsel_group #(
   parameter int unsigned AW        = 32,
   parameter int unsigned BLK_INSTR = 8,
   parameter int unsigned GROUP_MAX = 4,
   localparam int unsigned WI = $clog2(BLK_INSTR),
   localparam int unsigned GW = $clog2(GROUP_MAX + 1)
) (
   input  logic [AW-1:0] addr_i,
   output logic [GW-1:0] group_o
);
   localparam int unsigned RW = WI + 1;

   logic [WI-1:0] word_idx;
   logic [RW-1:0] remain;

   assign word_idx = addr_i[WI+fsel_pkg::INSTR_SHIFT-1:fsel_pkg::INSTR_SHIFT];
   assign remain   = RW'(BLK_INSTR) - RW'(word_idx);

   generate
      if (GROUP_MAX >= BLK_INSTR) begin : g_whole_block
         assign group_o = GW'(remain);
      end else begin : g_clamped
         assign group_o = (remain < RW'(GROUP_MAX)) ? GW'(remain) : GW'(GROUP_MAX);
      end
   endgenerate

endmodule

// File: rtl/fsel_redirect_arb.sv
module fsel_redirect_arb #(
   parameter int unsigned NSTG = 3,
   parameter int unsigned AW   = 32,
   localparam int unsigned PW = $clog2(NSTG + 1)
) (
   input  logic [NSTG-1:0]    vld_i,
   input  logic [NSTG*AW-1:0] tgt_i,
   output logic               any_o,
   output logic [AW-1:0]      tgt_o,
   output logic [NSTG-1:0]    kill_o,
   output logic [PW-1:0]      penalty_o
);
   // Index 0 is the earliest stage; a higher index overrides a lower one.
   always_comb begin
      any_o     = 1'b0;
      tgt_o     = '0;
      kill_o    = '0;
      penalty_o = '0;
      for (int i = 0; i < NSTG; i++) begin
         if (vld_i[i]) begin
            any_o     = 1'b1;
            tgt_o     = tgt_i[i*AW +: AW];
            penalty_o = PW'(i + 1);
            for (int j = 0; j < NSTG; j++) begin
               kill_o[j] = (j <= i);
            end
         end
      end
   end

endmodule

// File: rtl/fsel_pc_reg.sv
module fsel_pc_reg #(
   parameter int unsigned   AW        = 32,
   parameter logic [AW-1:0] RESET_VEC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] d_i,
   output logic [AW-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RESET_VEC;
      else        q_o <= d_i;
   end
endmodule

// File: rtl/fetch_addr_sel.sv
module fetch_addr_sel #(
   parameter int unsigned   AW        = 32,
   parameter int unsigned   BLK_BYTES = 32,
   parameter int unsigned   GROUP_MAX = 4,
   parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000,
   localparam int unsigned BLK_INSTR = BLK_BYTES / fsel_pkg::INSTR_BYTES,
   localparam int unsigned GW        = $clog2(GROUP_MAX + 1),
   localparam int unsigned NSTG      = 3,
   localparam int unsigned PW        = $clog2(NSTG + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall_i,
   input  logic            btac_hit_i,
   input  logic [AW-1:0]   btac_tgt_i,
   input  logic            dec_redir_i,
   input  logic [AW-1:0]   dec_tgt_i,
   input  logic            dec_via_lnk_i,
   input  logic            lnk_pend_i,
   input  logic            dsp_redir_i,
   input  logic [AW-1:0]   dsp_tgt_i,
   input  logic            exe_redir_i,
   input  logic [AW-1:0]   exe_tgt_i,
   output logic [AW-1:0]   fetch_addr_o,
   output logic [GW-1:0]   group_o,
   output logic [AW-1:0]   next_addr_o,
   output logic [NSTG-1:0] kill_o,
   output logic [PW-1:0]   penalty_o
);
   import fsel_pkg::*;

   generate
      if (BLK_INSTR < 2 || (BLK_INSTR & (BLK_INSTR - 1)) != 0) begin : g_bad_blk
         $error("BLK_BYTES must give a power-of-two instruction count of at least 2");
      end
      if (GROUP_MAX < 1 || GROUP_MAX > BLK_INSTR) begin : g_bad_grp
         $error("GROUP_MAX must lie between 1 and the block instruction count");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("RESET_VEC must be instruction aligned");
      end
   endgenerate

   logic              dec_ok;
   logic [NSTG-1:0]   redir_vld;
   logic [NSTG*AW-1:0] redir_tgt;
   logic              redir_any;
   logic [AW-1:0]     redir_sel;
   logic [AW-1:0]     raw_next;
   fsel_src_e         src;

   // A link/count based decode fix is only trusted once that register is settled.
   assign dec_ok    = dec_redir_i & ~(dec_via_lnk_i & lnk_pend_i);
   assign redir_vld = {exe_redir_i, dsp_redir_i, dec_ok};
   assign redir_tgt = {exe_tgt_i, dsp_tgt_i, dec_tgt_i};

   fsel_redirect_arb #(.NSTG(NSTG), .AW(AW)) u_arb (
      .vld_i     (redir_vld),
      .tgt_i     (redir_tgt),
      .any_o     (redir_any),
      .tgt_o     (redir_sel),
      .kill_o    (kill_o),
      .penalty_o (penalty_o)
   );

   fsel_group #(.AW(AW), .BLK_INSTR(BLK_INSTR), .GROUP_MAX(GROUP_MAX)) u_grp (
      .addr_i  (fetch_addr_o),
      .group_o (group_o)
   );

   always_comb begin
      if (redir_any)       src = SEL_REDIR;
      else if (stall_i)    src = SEL_HOLD;
      else if (btac_hit_i) src = SEL_BTAC;
      else                 src = SEL_SEQ;
   end

   always_comb begin
      unique case (src)
         SEL_REDIR: raw_next = redir_sel;
         SEL_HOLD:  raw_next = fetch_addr_o;
         SEL_BTAC:  raw_next = btac_tgt_i;
         default:   raw_next = fetch_addr_o + (AW'(group_o) << INSTR_SHIFT);
      endcase
   end

   assign next_addr_o = {raw_next[AW-1:INSTR_SHIFT], {INSTR_SHIFT{1'b0}}};

   fsel_pc_reg #(.AW(AW), .RESET_VEC(RESET_VEC)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (next_addr_o),
      .q_o   (fetch_addr_o)
   );

endmodule

// File: rtl/fetch_addr_sel_chk.sv
module fetch_addr_sel_chk #(
   parameter int unsigned AW        = 32,
   parameter int unsigned GROUP_MAX = 4,
   parameter int unsigned GW        = 3,
   parameter int unsigned PW        = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stall_i,
   input logic          btac_hit_i,
   input logic          dec_redir_i,
   input logic          dec_via_lnk_i,
   input logic          lnk_pend_i,
   input logic          dsp_redir_i,
   input logic          exe_redir_i,
   input logic [AW-1:0] fetch_addr_o,
   input logic [GW-1:0] group_o,
   input logic [2:0]    kill_o,
   input logic [PW-1:0] penalty_o
);
   logic any_redir;
   assign any_redir = exe_redir_i | dsp_redir_i | (dec_redir_i & ~(dec_via_lnk_i & lnk_pend_i));

   // R2
   group_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (group_o != '0) && (group_o <= GW'(GROUP_MAX)));

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_redir && !stall_i && !btac_hit_i) |=>
      (fetch_addr_o == $past(fetch_addr_o) + (AW'($past(group_o)) << 2)));

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !any_redir) |=> $stable(fetch_addr_o));

   // R6
   exe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exe_redir_i |-> (kill_o == 3'b111 && penalty_o == PW'(3)));

   // R7
   kill_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_o[2] |-> kill_o[1]) and (kill_o[1] |-> kill_o[0]));

   // R8
   penalty_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      PW'($countones(kill_o)) == penalty_o);

   // R11
   aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_addr_o[1:0] == 2'b00);

endmodule

bind fetch_addr_sel fetch_addr_sel_chk #(
   .AW(AW), .GROUP_MAX(GROUP_MAX), .GW(GW), .PW(PW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .btac_hit_i(btac_hit_i),
   .dec_redir_i(dec_redir_i), .dec_via_lnk_i(dec_via_lnk_i), .lnk_pend_i(lnk_pend_i),
   .dsp_redir_i(dsp_redir_i), .exe_redir_i(exe_redir_i),
   .fetch_addr_o(fetch_addr_o), .group_o(group_o), .kill_o(kill_o), .penalty_o(penalty_o)
);

// File: tb/fetch_addr_sel_tb.sv
module fetch_addr_sel_tb;
   localparam logic [31:0] RST_VEC = 32'h0000_1000;
   localparam logic [31:0] T_BTAC  = 32'h0000_2000;
   localparam logic [31:0] T_DEC   = 32'h0000_3000;
   localparam logic [31:0] T_DSP   = 32'h0000_4000;
   localparam logic [31:0] T_EXE   = 32'h0000_5000;

   // Vector: {start address, stall, hit, dec, via_lnk, lnk_pend, dsp, exe}
   localparam int NV = 16;
   localparam logic [38:0] VEC [NV] = '{
      {32'h0000_1000, 7'b0000000},
      {32'h0000_1010, 7'b0000000},
      {32'h0000_1014, 7'b0000000},
      {32'h0000_1018, 7'b0000000},
      {32'h0000_101C, 7'b0000000},
      {32'h0000_1004, 7'b0100000},
      {32'h0000_1008, 7'b1000000},
      {32'h0000_1008, 7'b1100000},
      {32'h0000_1000, 7'b0010000},
      {32'h0000_1000, 7'b0011100},
      {32'h0000_1000, 7'b0011000},
      {32'h0000_1000, 7'b0111100},
      {32'h0000_1000, 7'b0110010},
      {32'h0000_1000, 7'b1010011},
      {32'h0000_1000, 7'b1000010},
      {32'h0000_100C, 7'b1010000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall_i = 1'b0, btac_hit_i = 1'b0, dec_redir_i = 1'b0;
   logic        dec_via_lnk_i = 1'b0, lnk_pend_i = 1'b0, dsp_redir_i = 1'b0, exe_redir_i = 1'b0;
   logic [31:0] btac_tgt_i = T_BTAC, dec_tgt_i = T_DEC, dsp_tgt_i = T_DSP, exe_tgt_i = T_EXE;
   logic [31:0] fetch_addr_o, next_addr_o;
   logic [2:0]  group_o, kill_o;
   logic [1:0]  penalty_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fetch_addr_sel u_dut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
      .btac_hit_i(btac_hit_i), .btac_tgt_i(btac_tgt_i),
      .dec_redir_i(dec_redir_i), .dec_tgt_i(dec_tgt_i),
      .dec_via_lnk_i(dec_via_lnk_i), .lnk_pend_i(lnk_pend_i),
      .dsp_redir_i(dsp_redir_i), .dsp_tgt_i(dsp_tgt_i),
      .exe_redir_i(exe_redir_i), .exe_tgt_i(exe_tgt_i),
      .fetch_addr_o(fetch_addr_o), .group_o(group_o), .next_addr_o(next_addr_o),
      .kill_o(kill_o), .penalty_o(penalty_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] grp_of(input logic [31:0] a);
      int rem;
      rem = 8 - int'(a[4:2]);
      return (rem < 4) ? 3'(rem) : 3'd4;
   endfunction

   task automatic clear_in();
      {stall_i, btac_hit_i, dec_redir_i, dec_via_lnk_i, lnk_pend_i, dsp_redir_i, exe_redir_i} = '0;
      exe_tgt_i = T_EXE;
   endtask

   task automatic load_pc(input logic [31:0] a);
      @(negedge clk);
      clear_in();
      exe_redir_i = 1'b1;
      exe_tgt_i   = a;
      @(negedge clk);
      clear_in();
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] st, ea;
      logic [6:0]  c;
      logic [2:0]  ek;
      logic [1:0]  ep;
      bit          dok;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 addr in reset", fetch_addr_o, RST_VEC);
      chk("R1 kill in reset", 32'(kill_o), 32'd0);
      rst_n = 1'b1;
      #1;
      chk("R1 addr after reset", fetch_addr_o, RST_VEC);
      chk("R2 group at reset vector", 32'(group_o), 32'd4);

      // Table walk: R2..R10
      for (int v = 0; v < NV; v++) begin
         st = VEC[v][38:7];
         c  = VEC[v][6:0];
         load_pc(st);
         chk("R10 exe redirect loads start", fetch_addr_o, st);
         {stall_i, btac_hit_i, dec_redir_i, dec_via_lnk_i, lnk_pend_i, dsp_redir_i, exe_redir_i} = c;
         dok = c[4] && !(c[3] && c[2]);
         if (c[0])       begin ea = T_EXE; ek = 3'b111; ep = 2'd3; end
         else if (c[1])  begin ea = T_DSP; ek = 3'b011; ep = 2'd2; end
         else if (dok)   begin ea = T_DEC; ek = 3'b001; ep = 2'd1; end
         else if (c[6])  begin ea = st;    ek = 3'b000; ep = 2'd0; end
         else if (c[5])  begin ea = T_BTAC; ek = 3'b000; ep = 2'd0; end
         else            begin ea = st + {27'd0, grp_of(st), 2'b00}; ek = 3'b000; ep = 2'd0; end
         #1;
         chk($sformatf("R2 group vec%0d", v), 32'(group_o), 32'(grp_of(st)));
         chk($sformatf("R7 kill vec%0d", v), 32'(kill_o), 32'(ek));
         chk($sformatf("R8 penalty vec%0d", v), 32'(penalty_o), 32'(ep));
         chk($sformatf("R6 next vec%0d (R3 R4 R5 R9)", v), next_addr_o, ea);
         @(negedge clk);
         chk($sformatf("R6 fetch vec%0d", v), fetch_addr_o, ea);
         clear_in();
      end

      // R11: unaligned target is aligned
      load_pc(32'h0000_5002);
      chk("R11 unaligned exe target", fetch_addr_o, 32'h0000_5000);
      @(negedge clk);
      dsp_redir_i = 1'b1;
      dsp_tgt_i   = 32'h0000_4007;
      #1;
      chk("R11 unaligned next addr", next_addr_o, 32'h0000_4004);
      @(negedge clk);
      dsp_redir_i = 1'b0;
      dsp_tgt_i   = T_DSP;

      // R3: sequential walk across a block edge from word 1
      load_pc(32'h0000_1004);
      @(negedge clk);
      chk("R3 walk step 1", fetch_addr_o, 32'h0000_1014);
      chk("R2 walk group tail", 32'(group_o), 32'd3);
      @(negedge clk);
      chk("R3 walk step 2", fetch_addr_o, 32'h0000_1020);
      @(negedge clk);
      chk("R3 walk step 3", fetch_addr_o, 32'h0000_1030);
      chk("R7 walk no kill", 32'(kill_o), 32'd0);

      // R5: multi-cycle stall hold
      stall_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 held over stall", fetch_addr_o, 32'h0000_1030);
      stall_i = 1'b0;

      // R1: reset reasserted mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset reload", fetch_addr_o, RST_VEC);
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule